// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is a memory-mapped mailbox between a host processor and a power-management microcontroller. The host uses a simple 32-bit register bus with a write strobe and a combinational read path. Before a command it stages up to four payload words and two 32-bit pointer words. It then writes a command word. If the mailbox is idle, that write marks it busy and sends a one-cycle doorbell to the controller. The doorbell carries the command word and the number of payload words the controller should fetch.

The controller has its own port. It reads payload words by index, fills a four-word response buffer, and reports the outcome with a one-cycle done strobe that carries an error flag and an 8-bit error code. One cycle after the strobe, the mailbox stores the outcome and drops busy. If the command asked for it, the mailbox also raises a level interrupt to the host, which stays high until the host acknowledges it through the status register. A host that does not ask for the interrupt polls the busy bit instead.

Neither side has a streaming interface. Both ports are plain register and strobe pins with no back-pressure, and the busy flag is the only flow control: while it is set, new commands and staging writes are dropped.

Top module: `ipc_mbox`

## Requirements
- R1: After reset the status word, the command word, both pointers and both buffers read 0, and `host_irq` and `ctl_doorbell` are low.
- R2: The host address map is as follows. The command word is at 0x00, status at 0x04, the source pointer at 0x08 and the destination pointer at 0x0C. Payload words are at 0x80, 0x84, 0x88 and 0x8C, and response words are at 0x90, 0x94, 0x98 and 0x9C. Any other address reads 0.
- R3: A command write that arrives while busy is clear is accepted. Busy reads 1 from the next cycle on. `ctl_doorbell` pulses high for exactly one cycle, in the cycle after the write. `ctl_cmd` shows the word, whose fields are: opcode in bits 7:0, interrupt request in bit 8, sub-opcode in bits 15:12, payload length in bytes in bits 23:16.
- R4: A command write made while busy is set is ignored. The stored command word is unchanged and no doorbell is sent.
- R5: Writes to the pointers or to the payload words while busy is set are ignored. `ctl_pay_data` returns payload word `ctl_pay_idx`.
- R6: `ctl_words` equals the length field rounded up to whole 4-byte words, and it saturates at 4 when the length is above 16.
- R7: A `ctl_done` strobe while busy is set is captured on the next edge. Busy clears, and the error flag and code update, on the edge after that. The code reads 0 when the error flag is 0. A strobe while busy is clear has no effect.
- R8: The status word layout is: bit 0 busy, bit 1 error, bit 2 interrupt pending, bits 23:16 error code. All other bits read 0.
- R9: Completion sets the interrupt-pending bit and `host_irq` only when bit 8 of the accepted command was 1. Both stay high until the host writes the status word with bit 2 set. A status write with bit 2 clear leaves them unchanged.
- R10: Accepting a new command clears the error flag and the error code.
- R11: Controller writes (`ctl_rsp_we`) to response word `ctl_rsp_idx` are visible to the host at 0x90 onward. Host writes to the response addresses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 8 | Host byte address, word aligned |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for `host_addr`, combinational |
| host_irq | output | 1 | Completion interrupt, level |
| ctl_doorbell | output | 1 | One-cycle pulse when a new command is accepted |
| ctl_cmd | output | 32 | Accepted command word |
| ctl_words | output | 3 | Payload word count derived from the length field |
| ctl_sptr | output | 32 | Source pointer |
| ctl_dptr | output | 32 | Destination pointer |
| ctl_pay_idx | input | 2 | Payload word index for controller reads |
| ctl_pay_data | output | 32 | Selected payload word |
| ctl_rsp_we | input | 1 | Controller response write strobe |
| ctl_rsp_idx | input | 2 | Response word index |
| ctl_rsp_data | input | 32 | Response write data |
| ctl_done | input | 1 | Completion strobe from the controller |
| ctl_err | input | 1 | Error flag qualifying `ctl_done` |
| ctl_code | input | 8 | Error code qualifying `ctl_done` |

## Verification
On every cycle, the assertions check the busy and doorbell handshake: an accepted command raises busy together with a single doorbell, a doorbell never appears without an accepted write, and a write made while busy leaves the command word intact. They also check that busy falls exactly two edges after a done strobe, that the error code is 0 whenever the error flag is clear, and that the interrupt only rises for a command with bit 8 set. Only the bench scenarios can show the address map, the payload word count for different lengths including saturation, the contents of both buffers, and that staging writes made while busy are dropped. The same holds for the acknowledge behaviour of the interrupt and the effect of a done strobe while idle.

// File: rtl/ipc_mbox_pkg.sv
package ipc_mbox_pkg;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 8;
  localparam int BUF_WORDS = 4;
  localparam int BUF_BYTES = BUF_WORDS * 4;
  localparam int IDX_W     = $clog2(BUF_WORDS);
  localparam int WCNT_W    = $clog2(BUF_WORDS + 1);
  localparam int CODE_W    = 8;

  // host register offsets
  localparam logic [ADDR_W-1:0] OFS_CMD  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_SRC  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_DST  = 8'h0C;
  localparam logic [3:0]        PAY_PAGE = 4'h8;  // 0x80..0x8C
  localparam logic [3:0]        RSP_PAGE = 4'h9;  // 0x90..0x9C

  // command word fields
  localparam int IRQ_REQ_BIT = 8;
  localparam int SUB_LSB     = 12;
  localparam int LEN_LSB     = 16;

  // status word fields
  localparam int ST_BUSY  = 0;
  localparam int ST_ERR   = 1;
  localparam int ST_IRQ   = 2;
  localparam int CODE_LSB = 16;

  typedef enum logic [CODE_W-1:0] {
    RC_OK          = 8'd0,
    RC_UNSUPPORTED = 8'd1,
    RC_NOT_TAKEN   = 8'd2,
    RC_CANNOT_DO   = 8'd3,
    RC_BAD_CMD     = 8'd4,
    RC_FAILED      = 8'd5,
    RC_SEC_REJ_A   = 8'd6,
    RC_SEC_REJ_B   = 8'd7
  } mbox_rc_e;
endpackage

// File: rtl/ipc_mbox_buf.sv
module ipc_mbox_buf #(
  parameter int WORDS = 4,
  parameter int DW    = 32,
  localparam int IW   = $clog2(WORDS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [IW-1:0]       widx,
  input  logic [DW-1:0]       wdata,
  output logic [WORDS*DW-1:0] words
);
  for (genvar i = 0; i < WORDS; i++) begin : g_word
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (we && widx == IW'(i)) q <= wdata;
    end
    assign words[i*DW +: DW] = q;
  end
endmodule

// File: rtl/ipc_mbox_ctrl.sv
module ipc_mbox_ctrl
  import ipc_mbox_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CODE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wr,
  input  logic [DW-1:0] cmd_wdata,
  input  logic          irq_ack,
  input  logic          ctl_done,
  input  logic          ctl_err,
  input  logic [CW-1:0] ctl_code,
  output logic          busy,
  output logic          doorbell,
  output logic [DW-1:0] cmd_q,
  output logic          err,
  output logic [CW-1:0] code,
  output logic          irq_flag
);
  logic          accept;
  logic          done_q;
  logic          err_q;
  logic [CW-1:0] code_q;

  assign accept = cmd_wr && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      doorbell <= 1'b0;
      cmd_q    <= '0;
      err      <= 1'b0;
      code     <= '0;
      irq_flag <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      code_q   <= '0;
    end else begin
      doorbell <= accept;
      done_q   <= ctl_done && busy && !done_q;
      err_q    <= ctl_err;
      code_q   <= ctl_err ? ctl_code : '0;
      if (accept) begin
        cmd_q <= cmd_wdata;
        busy  <= 1'b1;
        err   <= 1'b0;
        code  <= '0;
      end else if (done_q) begin
        busy <= 1'b0;
        err  <= err_q;
        code <= code_q;
      end
      if (done_q && cmd_q[IRQ_REQ_BIT]) irq_flag <= 1'b1;
      else if (irq_ack)                 irq_flag <= 1'b0;
    end
  end

  a_r3_accept_raises_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !busy) |=> (busy && doorbell));

  a_r3_doorbell_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    doorbell |-> ($past(cmd_wr) && !$past(busy)));

  a_r4_busy_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && busy) |=> ($stable(cmd_q) && !doorbell));

  a_r7_busy_falls: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_done && busy && !done_q) |=> ##1 !busy);

  a_r7_code_needs_err: assert property (@(posedge clk) disable iff (!rst_n)
    !err |-> (code == '0));

  a_r9_irq_only_requested: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> (cmd_q[IRQ_REQ_BIT] && !busy));
endmodule

// File: rtl/ipc_mbox.sv
module ipc_mbox
  import ipc_mbox_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_wr,
  input  logic [ADDR_W-1:0]   host_addr,
  input  logic [DATA_W-1:0]   host_wdata,
  output logic [DATA_W-1:0]   host_rdata,
  output logic                host_irq,
  output logic                ctl_doorbell,
  output logic [DATA_W-1:0]   ctl_cmd,
  output logic [WCNT_W-1:0]   ctl_words,
  output logic [DATA_W-1:0]   ctl_sptr,
  output logic [DATA_W-1:0]   ctl_dptr,
  input  logic [IDX_W-1:0]    ctl_pay_idx,
  output logic [DATA_W-1:0]   ctl_pay_data,
  input  logic                ctl_rsp_we,
  input  logic [IDX_W-1:0]    ctl_rsp_idx,
  input  logic [DATA_W-1:0]   ctl_rsp_data,
  input  logic                ctl_done,
  input  logic                ctl_err,
  input  logic [CODE_W-1:0]   ctl_code
);
  logic                      busy, err, irq_flag;
  logic [CODE_W-1:0]         code;
  logic [DATA_W-1:0]         cmd_q, status;
  logic [BUF_WORDS*DATA_W-1:0] pay_flat, rsp_flat;
  logic                      pay_hit, rsp_hit;
  logic [IDX_W-1:0]          host_idx;
  logic [7:0]                len;
  logic [8:0]                len_up;

  assign host_idx = host_addr[2 +: IDX_W];
  assign pay_hit  = host_addr[7:4] == PAY_PAGE && host_addr[1:0] == 2'b00;
  assign rsp_hit  = host_addr[7:4] == RSP_PAGE && host_addr[1:0] == 2'b00;

  ipc_mbox_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_wr    (host_wr && host_addr == OFS_CMD),
    .cmd_wdata (host_wdata),
    .irq_ack   (host_wr && host_addr == OFS_STAT && host_wdata[ST_IRQ]),
    .ctl_done  (ctl_done),
    .ctl_err   (ctl_err),
    .ctl_code  (ctl_code),
    .busy      (busy),
    .doorbell  (ctl_doorbell),
    .cmd_q     (cmd_q),
    .err       (err),
    .code      (code),
    .irq_flag  (irq_flag)
  );

  ipc_mbox_buf #(.WORDS(BUF_WORDS), .DW(DATA_W)) u_pay (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (host_wr && pay_hit && !busy),
    .widx  (host_idx),
    .wdata (host_wdata),
    .words (pay_flat)
  );

  ipc_mbox_buf #(.WORDS(BUF_WORDS), .DW(DATA_W)) u_rsp (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ctl_rsp_we),
    .widx  (ctl_rsp_idx),
    .wdata (ctl_rsp_data),
    .words (rsp_flat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_sptr <= '0;
      ctl_dptr <= '0;
    end else if (host_wr && !busy) begin
      if (host_addr == OFS_SRC) ctl_sptr <= host_wdata;
      if (host_addr == OFS_DST) ctl_dptr <= host_wdata;
    end
  end

  always_comb begin
    status = '0;
    status[ST_BUSY] = busy;
    status[ST_ERR]  = err;
    status[ST_IRQ]  = irq_flag;
    status[CODE_LSB +: CODE_W] = code;
  end

  always_comb begin
    if (pay_hit)      host_rdata = pay_flat[host_idx*DATA_W +: DATA_W];
    else if (rsp_hit) host_rdata = rsp_flat[host_idx*DATA_W +: DATA_W];
    else begin
      unique case (host_addr)
        OFS_CMD:  host_rdata = cmd_q;
        OFS_STAT: host_rdata = status;
        OFS_SRC:  host_rdata = ctl_sptr;
        OFS_DST:  host_rdata = ctl_dptr;
        default:  host_rdata = '0;
      endcase
    end
  end

  assign len    = cmd_q[LEN_LSB +: 8];
  assign len_up = {1'b0, len} + 9'd3;
  assign ctl_words = (len > 8'(BUF_BYTES)) ? WCNT_W'(BUF_WORDS) : WCNT_W'(len_up >> 2);

  assign ctl_cmd      = cmd_q;
  assign ctl_pay_data = pay_flat[ctl_pay_idx*DATA_W +: DATA_W];
  assign host_irq     = irq_flag;
endmodule

// File: tb/tb_ipc_mbox.sv
module tb_ipc_mbox;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [7:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        host_irq, ctl_doorbell;
  logic [31:0] ctl_cmd, ctl_sptr, ctl_dptr, ctl_pay_data;
  logic [2:0]  ctl_words;
  logic [1:0]  ctl_pay_idx = '0;
  logic        ctl_rsp_we = 1'b0;
  logic [1:0]  ctl_rsp_idx = '0;
  logic [31:0] ctl_rsp_data = '0;
  logic        ctl_done = 1'b0, ctl_err = 1'b0;
  logic [7:0]  ctl_code = '0;

  int checks = 0, errors = 0;
  bit finished = 0;

  typedef struct { logic [31:0] cmd; logic [2:0] words; } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  ipc_mbox dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic peek(input logic [7:0] a, output logic [31:0] d);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
    logic [31:0] d;
    @(negedge clk);
    peek(a, d);
    chk(req, d, exp);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  // driver: pushes the doorbell the scoreboard must see
  task automatic send_cmd(logic [31:0] c, logic [2:0] w);
    exp_t e;
    e.cmd = c; e.words = w;
    sb.push_back(e);
    wr(8'h00, c);
  endtask

  // controller completes; checks busy still set one cycle after strobe
  task automatic finish_cmd(logic e, logic [7:0] c, logic [31:0] exp_stat);
    logic [31:0] d;
    @(negedge clk);
    ctl_done = 1'b1; ctl_err = e; ctl_code = c;
    @(negedge clk);
    ctl_done = 1'b0; ctl_err = 1'b0; ctl_code = '0;
    peek(8'h04, d);
    chk("R7 busy held one cycle", d & 32'h1, 32'h1);
    @(negedge clk);
    peek(8'h04, d);
    chk("R7/R8 status after done", d, exp_stat);
  endtask

  // monitor: compares each doorbell against the scoreboard
  always @(negedge clk) begin
    if (rst_n && ctl_doorbell) begin
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R4 unexpected doorbell: actual cmd 0x%08h expected none", ctl_cmd);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (ctl_cmd !== e.cmd || ctl_words !== e.words) begin
          errors++;
          $display("FAIL R3/R6 doorbell: actual 0x%08h/%0d expected 0x%08h/%0d",
                   ctl_cmd, ctl_words, e.cmd, e.words);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_chk("R1 status", 8'h04, 32'h0);
    rd_chk("R1 command", 8'h00, 32'h0);
    rd_chk("R1 payload", 8'h88, 32'h0);
    rd_chk("R1 response", 8'h9C, 32'h0);
    chk("R1 irq", {31'b0, host_irq}, 32'h0);
    // R2 pointers and payload
    wr(8'h08, 32'h1000_0040);
    wr(8'h0C, 32'h2000_0080);
    chk("R2 sptr", ctl_sptr, 32'h1000_0040);
    rd_chk("R2 dptr read", 8'h0C, 32'h2000_0080);
    for (int i = 0; i < 4; i++) wr(8'h80 + 8'(4*i), 32'hC0DE_0000 + i);
    rd_chk("R2 payload read", 8'h84, 32'hC0DE_0001);
    rd_chk("R2 unmapped", 8'h44, 32'h0);
    ctl_pay_idx = 2'd2;
    #1 chk("R5 controller payload", ctl_pay_data, 32'hC0DE_0002);
    // R3 accept: op 0x23, sub 5, len 6 -> 2 words
    send_cmd((32'd6 << 16) | (32'd5 << 12) | 32'h23, 3'd2);
    peek(8'h04, d);
    chk("R3 busy on accept", d, 32'h1);
    // R4 dropped while busy
    wr(8'h00, 32'h0000_0077);
    rd_chk("R4 command kept", 8'h00, 32'h0006_5023);
    // R5 staging dropped while busy
    wr(8'h80, 32'hDEAD_BEEF);
    wr(8'h08, 32'h3333_3333);
    ctl_pay_idx = 2'd0;
    #1 chk("R5 payload kept", ctl_pay_data, 32'hC0DE_0000);
    chk("R5 sptr kept", ctl_sptr, 32'h1000_0040);
    // R11 response buffer
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      ctl_rsp_we = 1'b1; ctl_rsp_idx = 2'(i); ctl_rsp_data = 32'h5A5A_0000 + i;
    end
    @(negedge clk);
    ctl_rsp_we = 1'b0;
    rd_chk("R11 response read", 8'h94, 32'h5A5A_0001);
    wr(8'h90, 32'hFFFF_FFFF);
    rd_chk("R11 host write ignored", 8'h90, 32'h5A5A_0000);
    // R7 polled completion; code ignored when error flag clear
    finish_cmd(1'b0, 8'h33, 32'h0);
    chk("R9 no irq when not requested", {31'b0, host_irq}, 32'h0);
    // R9 interrupt completion with error code 6; len 16 -> 4 words
    send_cmd(32'h0010_0111, 3'd4);
    finish_cmd(1'b1, 8'd6, 32'h0006_0006);
    chk("R9 irq raised", {31'b0, host_irq}, 32'h1);
    wr(8'h04, 32'h0000_0001);
    chk("R9 write without bit2 ignored", {31'b0, host_irq}, 32'h1);
    wr(8'h04, 32'h0000_0004);
    chk("R9 irq cleared", {31'b0, host_irq}, 32'h0);
    rd_chk("R8 error kept after ack", 8'h04, 32'h0006_0002);
    // R6 saturation len 20 -> 4; R10 error cleared on accept
    send_cmd(32'h0014_0002, 3'd4);
    peek(8'h04, d);
    chk("R10 error cleared", d, 32'h1);
    finish_cmd(1'b0, 8'h00, 32'h0);
    // R7 done while idle ignored
    @(negedge clk);
    ctl_done = 1'b1; ctl_err = 1'b1; ctl_code = 8'd9;
    @(negedge clk);
    ctl_done = 1'b0; ctl_err = 1'b0; ctl_code = '0;
    repeat (2) @(negedge clk);
    peek(8'h04, d);
    chk("R7 idle done ignored", d, 32'h0);
    // R6 len 0 -> 0 words with irq; len 1 -> 1 word
    send_cmd(32'h0000_0105, 3'd0);
    finish_cmd(1'b0, 8'h00, 32'h4);
    wr(8'h04, 32'h4);
    send_cmd(32'h0001_0001, 3'd1);
    finish_cmd(1'b0, 8'h00, 32'h0);
    repeat (2) @(negedge clk);
    chk("R3 all doorbells seen", sb.size(), 32'h0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule